// File: doc/BRIEF.md
# Byte-Lane Registered Bus Transceiver

This block connects two 32-bit buses, called A and B, through four independent 8-bit lanes. Each lane has a capture register on each side. The A-side register samples the A bus and the B-side register samples the B bus. For each direction, a per-lane select chooses what the far bus receives: either the live value on the near bus, or the value held in the near-side register. All data paths are non-inverting.

A per-lane output enable controls each direction. The two enables have opposite polarities. The enable that lets a lane drive B is active high. The enable that lets it drive A is active low. The bidirectional pins are split into an input vector, an output vector and a per-bit output-enable vector. The resolved bus is formed outside the block. This keeps the block fully synchronous and synthesizable.

Each lane's two capture strobes are level inputs sampled on the common clock. A register loads only on the clock where its strobe is first seen high. The select and enable inputs have no effect on capture. If a lane drives both buses with live data, its two outputs form a loop: once every other driver releases the lines, both buses keep their last value.

Top module: `trx_bus_xcvr`

## Requirements
- R1: On a clock where lane n's `cap_ab_i[n]` is high and was low at the previous clock (or reset has just been released), bits [8n+7:8n] of the A-side register load the value of `a_i` at that clock.
- R2: The B-side register follows the same rule, with strobe `cap_ba_i[n]` and data from `b_i`.
- R3: A strobe held high for several clocks causes exactly one load. A strobe that is low, or still high from the previous clock, leaves the register unchanged. Capture happens whatever the select and enable inputs are, including while the lane is isolated.
- R4: When `oe_ab_i[n]` is 1, bits [8n+7:8n] of `b_oe_o` are all 1. When it is 0, they are all 0 and the lane does not drive B.
- R5: When `oe_ba_ni[n]` is 0, bits [8n+7:8n] of `a_oe_o` are all 1. When it is 1, they are all 0 and the lane does not drive A.
- R6: When `sel_ab_i[n]` is 0, lane n of `b_o` equals lane n of `a_i` (live). When it is 1, it equals lane n of the A-side register (stored).
- R7: When `sel_ba_i[n]` is 0, lane n of `a_o` equals lane n of `b_i`. When it is 1, it equals lane n of the B-side register.
- R8: Asserting `rst_ni` low clears both registers and the strobe history, so stored transfers read zero after reset.
- R9: If a lane has both enables active and both selects at 0, then `a_o` equals `b_i` and `b_o` equals `a_i` on that lane. Once external drivers release both buses, the lane holds their last value.
- R10: Each lane follows only its own strobe, select and enable inputs. Lanes with different settings at the same time each behave as R1 to R9 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 32 | Resolved A bus value |
| b_i | input | 32 | Resolved B bus value |
| cap_ab_i | input | 4 | Per-lane capture strobe for the A-side register |
| cap_ba_i | input | 4 | Per-lane capture strobe for the B-side register |
| sel_ab_i | input | 4 | Per-lane source for B outputs (0 live, 1 stored) |
| sel_ba_i | input | 4 | Per-lane source for A outputs (0 live, 1 stored) |
| oe_ab_i | input | 4 | Per-lane B drive enable, active high |
| oe_ba_ni | input | 4 | Per-lane A drive enable, active low |
| a_o | output | 32 | Data driven onto the A bus |
| a_oe_o | output | 32 | Per-bit A drive enable |
| b_o | output | 32 | Data driven onto the B bus |
| b_oe_o | output | 32 | Per-bit B drive enable |

## Verification
The bench holds a strobe high across several clocks while the bus data changes, so a design that loads on every high level instead of on the rising edge would store the later value. It captures while the lane is isolated, so a design that gates capture with the enables would later show stale or zero stored data. It checks each enable alone and builds the bus-hold loop on one lane, so a swapped enable polarity leaves a bus floating, which the bench resolves to zero, and a broken loop drops the held value. Random per-lane settings mixed across lanes expose any crosstalk between lanes.

// File: rtl/trx_pkg.sv
package trx_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/trx_cap_reg.sv
module trx_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic prev_q;
  logic load;

  // load only on the first sampled high level of the strobe
  assign load = strobe_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      q_o    <= '0;
    end else begin
      prev_q <= strobe_i;
      if (load) q_o <= d_i;
    end
  end

  // R1
  cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !prev_q) |=> (q_o == $past(d_i)));

  // R3
  cap_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && !prev_q) |=> $stable(q_o));
endmodule

// File: rtl/trx_lane.sv
module trx_lane
  import trx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         oe_ab_i,
  input  logic         oe_ba_ni,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  src_sel_e     src_ab;
  src_sel_e     src_ba;

  trx_cap_reg #(.W(W)) u_reg_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cap_ab_i),
    .d_i      (a_i),
    .q_o      (reg_a)
  );

  trx_cap_reg #(.W(W)) u_reg_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cap_ba_i),
    .d_i      (b_i),
    .q_o      (reg_b)
  );

  assign src_ab = src_sel_e'(sel_ab_i);
  assign src_ba = src_sel_e'(sel_ba_i);

  assign b_o    = (src_ab == SRC_STORED) ? reg_a : a_i;
  assign a_o    = (src_ba == SRC_STORED) ? reg_b : b_i;
  // opposite enable polarities per direction
  assign b_oe_o = {W{oe_ab_i}};
  assign a_oe_o = {W{~oe_ba_ni}};

  // R6
  live_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ab_i |-> (b_o == a_i));

  // R7
  live_ba_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ba_i |-> (a_o == b_i));

  // R9
  keeper_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ab_i && !oe_ba_ni && !sel_ab_i && !sel_ba_i) |-> (a_o == b_i && b_o == a_i));
endmodule

// File: rtl/trx_bus_xcvr.sv
module trx_bus_xcvr #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [LANES-1:0] cap_ab_i,
  input  logic [LANES-1:0] cap_ba_i,
  input  logic [LANES-1:0] sel_ab_i,
  input  logic [LANES-1:0] sel_ba_i,
  input  logic [LANES-1:0] oe_ab_i,
  input  logic [LANES-1:0] oe_ba_ni,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     a_oe_o,
  output logic [W-1:0]     b_o,
  output logic [W-1:0]     b_oe_o
);
  // R10: lanes share only the clock and reset
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    trx_lane #(.W(LANE_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_i      (a_i[l*LANE_W +: LANE_W]),
      .b_i      (b_i[l*LANE_W +: LANE_W]),
      .cap_ab_i (cap_ab_i[l]),
      .cap_ba_i (cap_ba_i[l]),
      .sel_ab_i (sel_ab_i[l]),
      .sel_ba_i (sel_ba_i[l]),
      .oe_ab_i  (oe_ab_i[l]),
      .oe_ba_ni (oe_ba_ni[l]),
      .a_o      (a_o[l*LANE_W +: LANE_W]),
      .a_oe_o   (a_oe_o[l*LANE_W +: LANE_W]),
      .b_o      (b_o[l*LANE_W +: LANE_W]),
      .b_oe_o   (b_oe_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: tb/sim_trx_bus_xcvr.sv
module sim_trx_bus_xcvr;
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int W          = LANES * LANE_W;
  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0]     a_bus = '0, b_bus = '0;
  logic [LANES-1:0] cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [LANES-1:0] oe_ab = '0, oe_ba_n = '1;
  logic [W-1:0]     a_o, a_oe, b_o, b_oe;

  logic [W-1:0]     ext_a = '0, ext_b = '0;
  logic [LANES-1:0] ext_a_en = '0, ext_b_en = '0;

  logic [W-1:0]     exp_ra = '0, exp_rb = '0;
  logic [LANES-1:0] prev_ab = '0, prev_ba = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  trx_bus_xcvr #(.LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .a_i      (a_bus),
    .b_i      (b_bus),
    .cap_ab_i (cap_ab),
    .cap_ba_i (cap_ba),
    .sel_ab_i (sel_ab),
    .sel_ba_i (sel_ba),
    .oe_ab_i  (oe_ab),
    .oe_ba_ni (oe_ba_n),
    .a_o      (a_o),
    .a_oe_o   (a_oe),
    .b_o      (b_o),
    .b_oe_o   (b_oe)
  );

  function automatic logic [W-1:0] widen(input logic [LANES-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[i / LANE_W];
    return r;
  endfunction

  // external driver wins, then the block, else the line floats to 0
  function automatic logic [W-1:0] resolve(input logic [LANES-1:0] xen, input logic [W-1:0] x,
                                           input logic [W-1:0] oe, input logic [W-1:0] d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = xen[i / LANE_W] ? x[i] : (oe[i] ? d[i] : 1'b0);
    return r;
  endfunction

  task automatic settle();
    logic [W-1:0] na, nb;
    repeat (6) begin
      na = resolve(ext_a_en, ext_a, a_oe, a_o);
      nb = resolve(ext_b_en, ext_b, b_oe, b_o);
      a_bus = na;
      b_bus = nb;
      #1;
    end
  endtask

  // expected bus values from the requirement rules, iterated to a fixed point
  task automatic predict(output logic [W-1:0] ea, output logic [W-1:0] eb);
    logic [W-1:0] na, nb;
    ea = a_bus;
    eb = b_bus;
    repeat (4) begin
      for (int l = 0; l < LANES; l++) begin
        if (ext_a_en[l])       na[l*LANE_W +: LANE_W] = ext_a[l*LANE_W +: LANE_W];
        else if (!oe_ba_n[l])  na[l*LANE_W +: LANE_W] = sel_ba[l] ? exp_rb[l*LANE_W +: LANE_W] : eb[l*LANE_W +: LANE_W];
        else                   na[l*LANE_W +: LANE_W] = '0;
        if (ext_b_en[l])       nb[l*LANE_W +: LANE_W] = ext_b[l*LANE_W +: LANE_W];
        else if (oe_ab[l])     nb[l*LANE_W +: LANE_W] = sel_ab[l] ? exp_ra[l*LANE_W +: LANE_W] : ea[l*LANE_W +: LANE_W];
        else                   nb[l*LANE_W +: LANE_W] = '0;
      end
      ea = na;
      eb = nb;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // settle, check outputs, clock once and update the register model
  task automatic step();
    logic [W-1:0] ea, eb;
    settle();
    predict(ea, eb);
    check(a_bus == ea, "R7 R5 R10 A bus", a_bus, ea);
    check(b_bus == eb, "R6 R4 R10 B bus", b_bus, eb);
    check(a_oe == widen(~oe_ba_n), "R5 A enable", a_oe, widen(~oe_ba_n));
    check(b_oe == widen(oe_ab), "R4 B enable", b_oe, widen(oe_ab));
    @(posedge clk);
    for (int l = 0; l < LANES; l++) begin
      if (cap_ab[l] && !prev_ab[l]) exp_ra[l*LANE_W +: LANE_W] = a_bus[l*LANE_W +: LANE_W];
      if (cap_ba[l] && !prev_ba[l]) exp_rb[l*LANE_W +: LANE_W] = b_bus[l*LANE_W +: LANE_W];
    end
    prev_ab = cap_ab;
    prev_ba = cap_ba;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h51c3);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R8: both stored paths read zero after reset
    oe_ab = '1; oe_ba_n = '0; sel_ab = '1; sel_ba = '1;
    step();
    check(a_bus == '0, "R8 stored B after reset", a_bus, '0);
    check(b_bus == '0, "R8 stored A after reset", b_bus, '0);

    // R3 R1 R2: capture while isolated, then hold strobes high while data moves
    oe_ab = '0; oe_ba_n = '1;
    ext_a_en = '1; ext_b_en = '1;
    ext_a = 32'h11223344; ext_b = 32'hA5A55A5A;
    cap_ab = '1; cap_ba = '1;
    step();
    check(a_oe == '0, "R5 isolated A enable", a_oe, '0);
    check(b_oe == '0, "R4 isolated B enable", b_oe, '0);
    ext_a = 32'hFFFF0000; ext_b = 32'h0F0F0F0F;
    step();
    step();
    cap_ab = '0; cap_ba = '0;
    ext_a_en = '0; ext_b_en = '0;
    oe_ab = '1; oe_ba_n = '0;
    step();
    check(b_bus == 32'h11223344, "R1 R3 stored A on B", b_bus, 32'h11223344);
    check(a_bus == 32'hA5A55A5A, "R2 R3 stored B on A", a_bus, 32'hA5A55A5A);

    // R6 R10: only lane 2 drives B, live from A
    oe_ab = 4'b0100; oe_ba_n = '1; sel_ab = '0;
    ext_a_en = '1; ext_b_en = 4'b1011;
    ext_a = 32'hDEADBEEF; ext_b = 32'h01020304;
    step();
    check(b_bus == 32'h01AD0304, "R6 R10 live lane 2", b_bus, 32'h01AD0304);

    // R9: lane 1 forms the keeper loop and holds 0x5A after release
    oe_ab = 4'b0010; oe_ba_n = '1; sel_ab = '0; sel_ba = '0;
    ext_a_en = '1; ext_b_en = 4'b1101;
    ext_a = 32'h00005A00; ext_b = 32'h0;
    step();
    oe_ba_n = 4'b1101;
    step();
    ext_a_en = 4'b1101;
    ext_a = 32'h0;
    step();
    check(a_bus[15:8] == 8'h5A, "R9 A held", {24'h0, a_bus[15:8]}, 32'h5A);
    check(b_bus[15:8] == 8'h5A, "R9 B held", {24'h0, b_bus[15:8]}, 32'h5A);
    step();
    check(a_bus[15:8] == 8'h5A && b_bus[15:8] == 8'h5A, "R9 hold persists",
          {16'h0, a_bus[15:8], b_bus[15:8]}, 32'h5A5A);

    // reset the loop lane out of contention before random traffic
    oe_ab = '0; oe_ba_n = '1; ext_a_en = '1; ext_b_en = '1;
    step();

    // R10 R1 R2 R6 R7: random per-lane settings, no live-live loops
    for (int n = 0; n < 400; n++) begin
      cap_ab  = LANES'($urandom);
      cap_ba  = LANES'($urandom);
      sel_ab  = LANES'($urandom);
      sel_ba  = LANES'($urandom);
      oe_ab   = LANES'($urandom);
      oe_ba_n = LANES'($urandom);
      for (int l = 0; l < LANES; l++)
        if (oe_ab[l] && !oe_ba_n[l] && !sel_ab[l] && !sel_ba[l]) sel_ab[l] = 1'b1;
      ext_a_en = oe_ba_n;
      ext_b_en = ~oe_ab;
      ext_a = $urandom;
      ext_b = $urandom;
      step();
    end

    finish_run();
  end
endmodule